// File: doc/BRIEF.md
# Dual-Form 8-Bit Maximal-Length Pseudo-Random Bit Generator

This block produces a pseudo-random bit stream from an 8-bit linear feedback shift register. The register can advance in either of two feedback forms. In the toggle-mask form, the state shifts right and a fixed tap word is XORed in whenever a 1 leaves the register. In the parity-feedback form, the state shifts right and the bit entering at the top is the parity of a mirrored tap set. The two forms describe the same recurrence, so they emit the same output stream. Their 8-bit states differ for the same position in that stream.

A mode change is accepted only while stepping is paused. When the form changes, the block translates the state into the other form's representation, so the output stream continues with no break. A seed can be loaded at any time, and a zero seed is replaced so the register cannot lock up. The block also collects eight consecutive fresh output bits into a byte and pulses a valid flag when that byte is complete.

Top module: `lfsr_dual_form`

## Requirements
- R1: During and after synchronous reset (`rst` high at a clock edge), `state` = 8'h01, the form is toggle-mask, and `out_bit`, `rand_byte` and `byte_valid` are 0.
- R2: In toggle-mask form (`mode_sel` 0), a step moves the state right one place with 0 entering bit 7. If the bit that left (old bit 0) was 1, the result is XORed with 8'hB8.
- R3: In parity-feedback form (`mode_sel` 1), a step moves the state right one place. The bit entering bit 7 is the XOR of old state bits 4, 3, 2 and 0 (tap word 8'h1D, the bit-mirror of 8'hB8). No rotate of the leaving bit is ever used.
- R4: On every step, `out_bit` takes the old state bit 0, one cycle after the step is requested. `out_bit` holds its value while no step is taken.
- R5: In both forms, 255 consecutive steps visit every non-zero state exactly once and then return to the starting state. `state` is never zero.
- R6: `load_en` takes priority over a step, and the next state is `seed`, except that a zero seed gives 8'h01. A load clears the byte collection. A load in the same cycle as a mode change stores the seed untranslated, in the new form.
- R7: `mode_sel` is sampled only in cycles where `step_en` is low. While `step_en` is high, it has no effect.
- R8: A mode change without a load translates the state so that the stream continues unbroken. Going to parity-feedback form, the new state is the next 8 output bits with the earliest bit in bit 0. Going back, the new state is the toggle-mask state that yields that same continuation.
- R9: A mode change clears the byte collection, so the next byte holds 8 bits produced after the change.
- R10: One cycle after the 8th step since the last clear, `byte_valid` is high for exactly one cycle. At that point `rand_byte` holds those 8 bits, with the earliest bit in bit 0. `rand_byte` is unchanged at all other times.
- R11: A cycle with no step, no load and no mode change leaves `state` unchanged and `byte_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the register one step |
| mode_sel | input | 1 | Requested form: 0 toggle-mask, 1 parity-feedback |
| load_en | input | 1 | Load `seed` into the state |
| seed | input | 8 | Seed value, zero replaced by 8'h01 |
| out_bit | output | 1 | Bit shifted out on the latest step |
| state | output | 8 | Current register state |
| rand_byte | output | 8 | Last completed byte of fresh output bits |
| byte_valid | output | 1 | One-cycle pulse when `rand_byte` is updated |

## Verification
The hardest case to reach from the ports is a form change in the middle of a long run. Here stream continuity, the translated state and the cleared byte count must all hold together. The bench gets there by running a full 255-step toggle-mask sweep, which leaves seven uncollected bits. It then pauses and switches form, sweeps all 255 states in the other form while toggling `mode_sel` on every step, and switches back. Each state is compared against a stream model that keeps running in toggle-mask form throughout.

// File: rtl/lfsr_dual_pkg.sv
package lfsr_dual_pkg;

    // Feedback form of the register
    typedef enum logic {
        FORM_TOGGLE = 1'b0,
        FORM_PARITY = 1'b1
    } form_e;

endpackage

// File: rtl/lfsr_galois_step.sv
// One right-shift step of the toggle-mask form.
module lfsr_galois_step #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'hB8
) (
    input  logic [WIDTH-1:0] state_i,
    output logic [WIDTH-1:0] next_o,
    output logic             shout_o
);

    always_comb begin
        shout_o = state_i[0];
        next_o  = {1'b0, state_i[WIDTH-1:1]};
        if (state_i[0]) begin
            next_o = next_o ^ TAPS;
        end
    end

endmodule

// File: rtl/lfsr_fib_step.sv
// One right-shift step of the parity-feedback form; taps are the mirror of TAPS.
module lfsr_fib_step #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'hB8
) (
    input  logic [WIDTH-1:0] state_i,
    output logic [WIDTH-1:0] next_o,
    output logic             shout_o
);

    logic [WIDTH-1:0] mirror_taps;

    for (genvar j = 0; j < WIDTH; j++) begin : g_mirror
        assign mirror_taps[j] = TAPS[WIDTH-1-j];
    end

    always_comb begin
        shout_o = state_i[0];
        next_o  = {^(state_i & mirror_taps), state_i[WIDTH-1:1]};
    end

endmodule

// File: rtl/lfsr_form_xlate.sv
// Translates a state between the two forms while keeping the output stream.
module lfsr_form_xlate #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'hB8
) (
    input  logic [WIDTH-1:0] state_i,
    output logic [WIDTH-1:0] to_parity_o,
    output logic [WIDTH-1:0] to_toggle_o
);

    // toggle -> parity: the parity state is the window of the next WIDTH output bits
    always_comb begin
        logic [WIDTH-1:0] walk;
        walk = state_i;
        for (int k = 0; k < WIDTH; k++) begin
            to_parity_o[k] = walk[0];
            walk = {1'b0, walk[WIDTH-1:1]} ^ (walk[0] ? TAPS : '0);
        end
    end

    // parity -> toggle: undo the tap contributions accumulated in each stage
    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            logic acc;
            acc = state_i[k];
            for (int i = 0; i < k; i++) begin
                acc = acc ^ (TAPS[k-1-i] & state_i[i]);
            end
            to_toggle_o[k] = acc;
        end
    end

endmodule

// File: rtl/lfsr_dual_form.sv
module lfsr_dual_form
    import lfsr_dual_pkg::*;
#(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'hB8,
    parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             mode_sel,
    input  logic             load_en,
    input  logic [WIDTH-1:0] seed,
    output logic             out_bit,
    output logic [WIDTH-1:0] state,
    output logic [WIDTH-1:0] rand_byte,
    output logic             byte_valid
);

    localparam int             CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0]  LAST = CW'(WIDTH - 1);

    typedef struct packed {
        form_e            mode;
        logic [WIDTH-1:0] lfsr;
        logic [CW-1:0]    cnt;
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] byte_o;
        logic             valid;
        logic             bit_o;
    } regs_t;

    regs_t q_r, d_r;

    logic [WIDTH-1:0] tog_next_w, par_next_w;
    logic [WIDTH-1:0] to_par_w, to_tog_w;
    logic             tog_out_w, par_out_w;
    logic             mode_now;

    lfsr_galois_step #(.WIDTH(WIDTH), .TAPS(TAPS)) u_tog (
        .state_i (q_r.lfsr),
        .next_o  (tog_next_w),
        .shout_o (tog_out_w)
    );

    lfsr_fib_step #(.WIDTH(WIDTH), .TAPS(TAPS)) u_par (
        .state_i (q_r.lfsr),
        .next_o  (par_next_w),
        .shout_o (par_out_w)
    );

    lfsr_form_xlate #(.WIDTH(WIDTH), .TAPS(TAPS)) u_xlate (
        .state_i     (q_r.lfsr),
        .to_parity_o (to_par_w),
        .to_toggle_o (to_tog_w)
    );

    always_comb begin
        form_e            req_d;
        logic             chg_d;
        logic             shout_d;
        logic [WIDTH-1:0] stepped_d;

        d_r       = q_r;
        d_r.valid = 1'b0;
        req_d     = form_e'(mode_sel);
        chg_d     = !step_en && (req_d != q_r.mode);
        stepped_d = (q_r.mode == FORM_TOGGLE) ? tog_next_w : par_next_w;
        shout_d   = (q_r.mode == FORM_TOGGLE) ? tog_out_w  : par_out_w;

        if (!step_en) begin
            d_r.mode = req_d;
        end

        if (load_en) begin
            d_r.lfsr = (seed == '0) ? WIDTH'(1) : seed;
            d_r.cnt  = '0;
        end else if (chg_d) begin
            d_r.lfsr = (q_r.mode == FORM_TOGGLE) ? to_par_w : to_tog_w;
            d_r.cnt  = '0;
        end else if (step_en) begin
            d_r.lfsr  = stepped_d;
            d_r.bit_o = shout_d;
            d_r.acc   = {shout_d, q_r.acc[WIDTH-1:1]};
            if (q_r.cnt == LAST) begin
                d_r.cnt    = '0;
                d_r.byte_o = d_r.acc;
                d_r.valid  = 1'b1;
            end else begin
                d_r.cnt = q_r.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r.mode   <= FORM_TOGGLE;
            q_r.lfsr   <= (SEED == '0) ? WIDTH'(1) : SEED;
            q_r.cnt    <= '0;
            q_r.acc    <= '0;
            q_r.byte_o <= '0;
            q_r.valid  <= 1'b0;
            q_r.bit_o  <= 1'b0;
        end else begin
            q_r <= d_r;
        end
    end

    assign mode_now   = q_r.mode;
    assign out_bit    = q_r.bit_o;
    assign state      = q_r.lfsr;
    assign rand_byte  = q_r.byte_o;
    assign byte_valid = q_r.valid;

endmodule

// File: rtl/lfsr_dual_form_chk.sv
module lfsr_dual_form_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             step_en,
    input logic             mode_sel,
    input logic             load_en,
    input logic [WIDTH-1:0] seed,
    input logic             out_bit,
    input logic [WIDTH-1:0] state,
    input logic             byte_valid,
    input logic             mode_now
);

    // R5
    state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    // R4
    out_bit_src_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load_en) |=> (out_bit == $past(state[0])));

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !load_en && (mode_sel == mode_now)) |=> ($stable(state) && !byte_valid));

    // R6
    zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (load_en && (seed == '0)) |=> (state == WIDTH'(1)));

    // R7
    mode_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (mode_now == $past(mode_now)));

endmodule

bind lfsr_dual_form lfsr_dual_form_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .mode_sel   (mode_sel),
    .load_en    (load_en),
    .seed       (seed),
    .out_bit    (out_bit),
    .state      (state),
    .byte_valid (byte_valid),
    .mode_now   (mode_now)
);

// File: tb/lfsr_dual_form_bench.sv
module lfsr_dual_form_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic       mode_sel = 1'b0;
    logic       load_en = 1'b0;
    logic [7:0] seed = 8'h00;
    logic       out_bit;
    logic [7:0] state;
    logic [7:0] rand_byte;
    logic       byte_valid;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic cur_mode = 1'b0;
    logic [7:0] macc = 8'h00;
    int   mcnt = 0;
    logic [7:0] last_byte = 8'h00;
    logic [7:0] gm;
    logic [7:0] fm;
    bit   seen [256];

    always #5 clk = ~clk;

    lfsr_dual_form u_lfsr_dual_form (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .mode_sel   (mode_sel),
        .load_en    (load_en),
        .seed       (seed),
        .out_bit    (out_bit),
        .state      (state),
        .rand_byte  (rand_byte),
        .byte_valid (byte_valid)
    );

    function automatic logic [7:0] tog_nx(input logic [7:0] s);
        return (s >> 1) ^ (s[0] ? 8'hB8 : 8'h00);
    endfunction

    function automatic logic [7:0] par_nx(input logic [7:0] s);
        return {s[4] ^ s[3] ^ s[2] ^ s[0], s[7:1]};
    endfunction

    function automatic logic [7:0] window(input logic [7:0] s);
        logic [7:0] w;
        logic [7:0] t;
        t = s;
        for (int k = 0; k < 8; k++) begin
            w[k] = t[0];
            t = tog_nx(t);
        end
        return w;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic st, input logic ld, input logic md, input logic [7:0] sd);
        step_en  = st;
        load_en  = ld;
        mode_sel = md;
        seed     = sd;
        @(posedge clk);
        #1;
        step_en  = 1'b0;
        load_en  = 1'b0;
        mode_sel = cur_mode;
    endtask

    task automatic step_chk(input string tag, input logic [7:0] exp_s, input logic exp_b,
                            input logic noise);
        cyc(1'b1, 1'b0, noise, 8'h00);
        chk(tag, state, exp_s);
        chk("R4 out_bit", {7'd0, out_bit}, {7'd0, exp_b});
        chk("R5 nonzero", {7'd0, state != 8'h00}, 8'h01);
        macc = {exp_b, macc[7:1]};
        mcnt++;
        if (mcnt == 8) begin
            chk("R10 valid pulse", {7'd0, byte_valid}, 8'h01);
            chk("R10 byte", rand_byte, macc);
            last_byte = macc;
            mcnt = 0;
        end else begin
            chk("R9 R10 no pulse", {7'd0, byte_valid}, 8'h00);
            chk("R10 byte hold", rand_byte, last_byte);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic ob;
        int   dup;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 state", state, 8'h01);
        chk("R1 out_bit", {7'd0, out_bit}, 8'h00);
        chk("R1 rand_byte", rand_byte, 8'h00);
        chk("R1 valid", {7'd0, byte_valid}, 8'h00);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 state after release", state, 8'h01);

        // R2 R5: full toggle-mask sweep
        gm = 8'h01;
        dup = 0;
        foreach (seen[i]) seen[i] = 1'b0;
        for (int k = 0; k < 255; k++) begin
            ob = gm[0];
            gm = tog_nx(gm);
            step_chk("R2 toggle state", gm, ob, 1'b0);
            if (seen[state]) dup++;
            seen[state] = 1'b1;
        end
        chk("R5 toggle distinct", 8'(dup), 8'h00);
        chk("R5 toggle period", state, 8'h01);

        // R11 idle hold
        ob = out_bit;
        cyc(1'b0, 1'b0, cur_mode, 8'h00);
        chk("R11 hold state", state, gm);
        chk("R11 no pulse", {7'd0, byte_valid}, 8'h00);
        chk("R4 out_bit hold", {7'd0, out_bit}, {7'd0, ob});

        // R8 R9: switch to parity form mid-byte (7 bits pending)
        cur_mode = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        chk("R8 to parity state", state, window(gm));
        mcnt = 0;

        // R3 R7 R5: parity sweep with mode_sel toggling while stepping
        dup = 0;
        foreach (seen[i]) seen[i] = 1'b0;
        for (int k = 0; k < 255; k++) begin
            ob = gm[0];
            gm = tog_nx(gm);
            step_chk("R7 R8 parity continues", window(gm), ob, k[0]);
            if (seen[state]) dup++;
            seen[state] = 1'b1;
        end
        chk("R5 parity distinct", 8'(dup), 8'h00);

        // R8 back to toggle form
        cur_mode = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 8'h00);
        chk("R8 to toggle state", state, gm);
        mcnt = 0;
        for (int k = 0; k < 20; k++) begin
            ob = gm[0];
            gm = tog_nx(gm);
            step_chk("R8 toggle continues", gm, ob, 1'b1);
        end

        // R6 zero seed, load priority over step
        cyc(1'b0, 1'b1, 1'b0, 8'h00);
        chk("R6 zero seed", state, 8'h01);
        ob = out_bit;
        cyc(1'b1, 1'b1, 1'b0, 8'hA5);
        chk("R6 load beats step", state, 8'hA5);
        chk("R6 out_bit untouched", {7'd0, out_bit}, {7'd0, ob});
        gm = 8'hA5;
        mcnt = 0;
        for (int k = 0; k < 12; k++) begin
            ob = gm[0];
            gm = tog_nx(gm);
            step_chk("R2 after load", gm, ob, 1'b0);
        end

        // R6 R3: raw load with simultaneous mode change, plain parity recurrence
        cur_mode = 1'b1;
        cyc(1'b0, 1'b1, 1'b1, 8'h3C);
        chk("R6 raw load parity", state, 8'h3C);
        fm = 8'h3C;
        mcnt = 0;
        for (int k = 0; k < 16; k++) begin
            ob = fm[0];
            fm = par_nx(fm);
            step_chk("R3 parity state", fm, ob, 1'b0);
            if (k == 7) chk("R3 first byte is seed", rand_byte, 8'h3C);
        end

        // R11 hold in parity form
        cyc(1'b0, 1'b0, 1'b1, 8'h00);
        chk("R11 hold parity", state, fm);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule